// File: doc/BRIEF.md
# Multiplexed LCD scan and blink sequencer

This block is the timing and level-selection core of a low-multiplex LCD driver. It walks through the backplane rows of a frame and reads a 24-column, 4-bit display memory. For every backplane and segment pin it produces a 2-bit code that names the voltage level the analog output stage must drive. Each frame has two halves of opposite polarity, so every segment sees a zero average voltage.

The drive configuration sets how many rows are scanned: static, two, three or four backplanes. A bias input selects half bias instead of third bias. A power-saving input shortens every clock divider by a factor of six. An output bank bit lets the static and two-row modes show the upper half of each memory word. Whole-display blinking runs at three selectable rates. In the static and two-row modes, blinking can alternate between the two memory banks instead of blanking. The bias resistor ladder and the cascade synchronisation pin lie outside this block.

Top module: `lcd_scan_seq`

## Requirements
- R1: Reset drives every backplane and segment code to 0, the level at the VDD rail, and loads four-row mode with normal power as the scan configuration.
- R2: A frame lasts FRAME_DIV clocks (default 2880) with `power_save` low, and FRAME_DIV/6 clocks with it high. It is split into 2·N equal slots, where N is the row count. The first N slots form the positive half and the last N slots form the negative half.
- R3: `drive_mode` gives N-1 (0 static, 1 two rows, 2 three rows, 3 four rows). Within each half, rows are scanned in ascending order from row 0 to row N-1. Row r of column c is read from `disp_mem[4c+r]`.
- R4: Level codes are 0 = VDD rail, 1 = one third, 2 = two thirds, 3 = VLCD rail. With third bias, in the positive half the active backplane is 0 and the others are 2. A lit segment is 3 and an unlit one is 1. In the negative half every code x becomes 3-x.
- R5: With half bias, or in static mode, codes use rails and a midpoint (code 1 = one half). In the positive half the active backplane is 0 and the others are 1. A lit segment is 3 and an unlit segment is 0. In the negative half the rails swap and the midpoint stays 1.
- R6: Physical backplane k takes its row from the mode. Static: all four show row 0. Two rows: k mod 2. Three rows: backplane 3 repeats row 1. Four rows: row k.
- R7: With `out_bank` high, static mode reads bit 2 instead of bit 0, and two-row mode reads bits 2 and 3 instead of bits 0 and 1. In the three- and four-row modes the bit has no effect.
- R8: `blink_rate` 0 turns blinking off. Codes 1, 2 and 3 give a blink period of 32, 64 and 128 frames, counted from the last scan restart. During the second half of each period every segment shows its unlit level, while the backplanes keep scanning.
- R9: With `blink_swap` high in static or two-row mode, the dark half of the blink period inverts the bank choice of R7 instead of blanking. In the other modes, blinking still blanks.
- R10: With `disp_en` low, every output code is 0 from the next clock on.
- R11: All outputs are registered and reflect the scan state and inputs one clock earlier. A change of `drive_mode` or `power_save` restarts the scan at row 0 of a positive half, with the blink count cleared. Outputs follow the new setting from the second clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| drive_mode | input | 2 | Row count minus one |
| bias_half | input | 1 | Selects half bias |
| disp_en | input | 1 | Display enable; low blanks all outputs |
| power_save | input | 1 | Divides all frame and blink dividers by six |
| out_bank | input | 1 | Shows the upper bank in static and two-row modes |
| blink_rate | input | 2 | Blink period select, 0 = off |
| blink_swap | input | 1 | Blink by bank swap where a second bank exists |
| disp_mem | input | 96 | Display memory, 4 bits per column |
| bp_lvl | output | 8 | Backplane level codes, 2 bits per backplane |
| seg_lvl | output | 48 | Segment level codes, 2 bits per segment |

## Verification
Every output code is due exactly one clock edge after the scan state and inputs that produce it. A change of mode or power setting first reaches the outputs at the second edge, and slot, frame and blink boundaries come every slot-length, frame-length and 16·2^rate-frame count of clocks after a restart. The bench keeps its own edge count since the last restart. At each rising edge it derives row, half, frame and blink phase from that count, and from those the expected codes. It compares them against the ports at the next falling edge, so each result is checked in the cycle it is due. A reduced FRAME_DIV keeps all three blink periods reachable.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

    localparam int ROWS = 4;

    typedef enum logic [1:0] {
        DRV_STATIC = 2'd0,
        DRV_MUX2   = 2'd1,
        DRV_MUX3   = 2'd2,
        DRV_MUX4   = 2'd3
    } drive_mode_e;

    typedef logic [1:0] lvl_t;

    localparam lvl_t LV_RAIL_LO = 2'd0;
    localparam lvl_t LV_ONE     = 2'd1;
    localparam lvl_t LV_TWO     = 2'd2;
    localparam lvl_t LV_RAIL_HI = 2'd3;

    typedef struct packed {
        drive_mode_e mode;
        logic        psave;
    } scan_cfg_t;

    typedef struct packed {
        logic [1:0] row;
        logic       phase;
    } slot_t;

    // Negative half: mirror around the midpoint; the half-bias midpoint is fixed.
    function automatic lvl_t mirror_lvl(lvl_t v, logic rails_mid, logic phase);
        if (!phase)
            return v;
        if (rails_mid && v == LV_ONE)
            return v;
        return LV_RAIL_HI - v;
    endfunction

    function automatic lvl_t bp_level(logic active, logic rails_mid, logic phase);
        lvl_t base;
        if (active)
            base = LV_RAIL_LO;
        else if (rails_mid)
            base = LV_ONE;
        else
            base = LV_TWO;
        return mirror_lvl(base, rails_mid, phase);
    endfunction

    function automatic lvl_t seg_level(logic lit, logic rails_mid, logic phase);
        lvl_t base;
        if (lit)
            base = LV_RAIL_HI;
        else if (rails_mid)
            base = LV_RAIL_LO;
        else
            base = LV_ONE;
        return mirror_lvl(base, rails_mid, phase);
    endfunction

    // Logical row carried by physical backplane k in a given mode.
    function automatic logic [1:0] bp_row(drive_mode_e m, logic [1:0] k);
        case (m)
            DRV_STATIC: return 2'd0;
            DRV_MUX2:   return {1'b0, k[0]};
            DRV_MUX3:   return (k == 2'd3) ? 2'd1 : k;
            default:    return k;
        endcase
    endfunction

endpackage

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer
    import lcd_scan_pkg::*;
#(
    parameter int FRAME_DIV  = 2880,
    parameter int PS_RATIO   = 6,
    parameter int BLINK_LOG2 = 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  scan_cfg_t             cfg_in,
    output scan_cfg_t             cfg_q,
    output slot_t                 slot_q,
    output logic [BLINK_LOG2+1:0] frame_q
);
    localparam int F_NORM = FRAME_DIV;
    localparam int F_SAVE = FRAME_DIV / PS_RATIO;
    localparam int CNT_W  = $clog2(F_NORM / 2 + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] slot_len;
    logic             restart;
    logic             slot_end;
    logic             row_last;

    always_comb begin
        case (cfg_q.mode)
            DRV_STATIC: slot_len = cfg_q.psave ? CNT_W'(F_SAVE / 2) : CNT_W'(F_NORM / 2);
            DRV_MUX2:   slot_len = cfg_q.psave ? CNT_W'(F_SAVE / 4) : CNT_W'(F_NORM / 4);
            DRV_MUX3:   slot_len = cfg_q.psave ? CNT_W'(F_SAVE / 6) : CNT_W'(F_NORM / 6);
            default:    slot_len = cfg_q.psave ? CNT_W'(F_SAVE / 8) : CNT_W'(F_NORM / 8);
        endcase
        restart  = (cfg_in != cfg_q);
        slot_end = (cnt_q == slot_len - 1'b1);
        row_last = (slot_q.row == 2'(cfg_q.mode));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '{mode: DRV_MUX4, psave: 1'b0};
            cnt_q   <= '0;
            slot_q  <= '0;
            frame_q <= '0;
        end else if (restart) begin
            cfg_q   <= cfg_in;
            cnt_q   <= '0;
            slot_q  <= '0;
            frame_q <= '0;
        end else if (slot_end) begin
            cnt_q <= '0;
            if (row_last) begin
                slot_q.row   <= '0;
                slot_q.phase <= ~slot_q.phase;
                if (slot_q.phase)
                    frame_q <= frame_q + 1'b1;
            end else begin
                slot_q.row <= slot_q.row + 1'b1;
            end
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    p_row_in_range_r3: assert property (@(posedge clk) disable iff (rst)
        slot_q.row <= 2'(cfg_q.mode));

    p_slot_moves_at_boundary_r2: assert property (@(posedge clk) disable iff (rst)
        !$stable(slot_q) |-> $past(slot_end || restart));

    p_frame_on_negative_end_r2: assert property (@(posedge clk) disable iff (rst)
        (!$stable(frame_q) && !$past(restart)) |-> $fell(slot_q.phase));

endmodule

// File: rtl/lcd_scan_blink.sv
module lcd_scan_blink
    import lcd_scan_pkg::*;
#(
    parameter int BLINK_LOG2 = 5
) (
    input  logic [1:0]            rate,
    input  logic                  alt,
    input  drive_mode_e           mode,
    input  logic [BLINK_LOG2+1:0] frame_cnt,
    output logic                  blank,
    output logic                  swap
);
    localparam int FC_W  = BLINK_LOG2 + 2;
    localparam int IDX_W = $clog2(FC_W);

    logic [IDX_W-1:0] idx;
    logic             dark_half;
    logic             has_alt_bank;

    always_comb begin
        idx          = IDX_W'(BLINK_LOG2 - 2 + int'(rate));
        dark_half    = (rate != 2'd0) && frame_cnt[idx];
        has_alt_bank = (mode == DRV_STATIC) || (mode == DRV_MUX2);
        swap         = dark_half && alt && has_alt_bank;
        blank        = dark_half && !swap;
    end

endmodule

// File: rtl/lcd_scan_drive.sv
module lcd_scan_drive
    import lcd_scan_pkg::*;
#(
    parameter int NUM_SEG = 24
) (
    input  logic                     clk,
    input  logic                     rst,
    input  drive_mode_e              mode,
    input  slot_t                    slot,
    input  logic                     bias_half,
    input  logic                     enable,
    input  logic                     out_bank,
    input  logic                     blank,
    input  logic                     swap,
    input  logic [NUM_SEG*ROWS-1:0]  mem,
    output logic [ROWS*2-1:0]        bp_q,
    output logic [NUM_SEG*2-1:0]     seg_q
);
    logic       rails_mid;
    logic       bank_alt;
    logic [1:0] bit_sel;
    lvl_t       bp_d  [ROWS];
    lvl_t       seg_d [NUM_SEG];

    always_comb begin
        rails_mid = bias_half || (mode == DRV_STATIC);
        bank_alt  = (out_bank ^ swap) && ((mode == DRV_STATIC) || (mode == DRV_MUX2));
        bit_sel   = slot.row + (bank_alt ? 2'd2 : 2'd0);
    end

    for (genvar k = 0; k < ROWS; k++) begin : g_bp
        assign bp_d[k] = enable
            ? bp_level(bp_row(mode, 2'(k)) == slot.row, rails_mid, slot.phase)
            : LV_RAIL_LO;
    end

    for (genvar c = 0; c < NUM_SEG; c++) begin : g_seg
        logic lit;
        assign lit      = mem[c*ROWS + int'(bit_sel)] && !blank;
        assign seg_d[c] = enable ? seg_level(lit, rails_mid, slot.phase) : LV_RAIL_LO;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bp_q  <= '0;
            seg_q <= '0;
        end else begin
            for (int k = 0; k < ROWS; k++)
                bp_q[k*2 +: 2] <= bp_d[k];
            for (int c = 0; c < NUM_SEG; c++)
                seg_q[c*2 +: 2] <= seg_d[c];
        end
    end

    p_reset_dark_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (bp_q == '0 && seg_q == '0));

    p_disabled_dark_r10: assert property (@(posedge clk) disable iff (rst)
        $past(!enable) |-> (bp_q == '0 && seg_q == '0));

    p_static_shared_r6: assert property (@(posedge clk) disable iff (rst)
        $past(mode == DRV_STATIC) |->
            (bp_q[3:2] == bp_q[1:0] && bp_q[5:4] == bp_q[1:0] && bp_q[7:6] == bp_q[1:0]));

    p_two_row_pairs_r6: assert property (@(posedge clk) disable iff (rst)
        $past(mode == DRV_MUX2) |-> (bp_q[5:4] == bp_q[1:0] && bp_q[7:6] == bp_q[3:2]));

    p_three_row_pair_r6: assert property (@(posedge clk) disable iff (rst)
        $past(mode == DRV_MUX3) |-> (bp_q[7:6] == bp_q[3:2]));

endmodule

// File: rtl/lcd_scan_seq.sv
module lcd_scan_seq
    import lcd_scan_pkg::*;
#(
    parameter int NUM_SEG    = 24,
    parameter int FRAME_DIV  = 2880,
    parameter int PS_RATIO   = 6,
    parameter int BLINK_LOG2 = 5
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [1:0]              drive_mode,
    input  logic                    bias_half,
    input  logic                    disp_en,
    input  logic                    power_save,
    input  logic                    out_bank,
    input  logic [1:0]              blink_rate,
    input  logic                    blink_swap,
    input  logic [NUM_SEG*4-1:0]    disp_mem,
    output logic [7:0]              bp_lvl,
    output logic [NUM_SEG*2-1:0]    seg_lvl
);
    scan_cfg_t             cfg_in;
    scan_cfg_t             cfg_q;
    slot_t                 slot;
    logic [BLINK_LOG2+1:0] frame_cnt;
    logic                  blank;
    logic                  swap;

    assign cfg_in = '{mode: drive_mode_e'(drive_mode), psave: power_save};

    lcd_scan_timer #(
        .FRAME_DIV (FRAME_DIV),
        .PS_RATIO  (PS_RATIO),
        .BLINK_LOG2(BLINK_LOG2)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q),
        .slot_q (slot),
        .frame_q(frame_cnt)
    );

    lcd_scan_blink #(
        .BLINK_LOG2(BLINK_LOG2)
    ) u_blink (
        .rate     (blink_rate),
        .alt      (blink_swap),
        .mode     (cfg_q.mode),
        .frame_cnt(frame_cnt),
        .blank    (blank),
        .swap     (swap)
    );

    lcd_scan_drive #(
        .NUM_SEG(NUM_SEG)
    ) u_drive (
        .clk      (clk),
        .rst      (rst),
        .mode     (cfg_q.mode),
        .slot     (slot),
        .bias_half(bias_half),
        .enable   (disp_en),
        .out_bank (out_bank),
        .blank    (blank),
        .swap     (swap),
        .mem      (disp_mem),
        .bp_q     (bp_lvl),
        .seg_q    (seg_lvl)
    );

endmodule

// File: tb/tb_lcd_scan_seq.sv
`timescale 1ns/1ps
module tb_lcd_scan_seq;
    localparam int FD = 144;
    localparam int NS = 24;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    drive_mode = 2'd3;
    logic          bias_half = 1'b0;
    logic          disp_en = 1'b0;
    logic          power_save = 1'b0;
    logic          out_bank = 1'b0;
    logic [1:0]    blink_rate = 2'd0;
    logic          blink_swap = 1'b0;
    logic [NS*4-1:0] disp_mem = 96'h5A3C_F00F_9966_12AB_C3E1_7D28;
    logic [7:0]    bp_lvl;
    logic [NS*2-1:0] seg_lvl;

    lcd_scan_seq #(.NUM_SEG(NS), .FRAME_DIV(FD)) dut (
        .clk(clk), .rst(rst), .drive_mode(drive_mode), .bias_half(bias_half),
        .disp_en(disp_en), .power_save(power_save), .out_bank(out_bank),
        .blink_rate(blink_rate), .blink_swap(blink_swap), .disp_mem(disp_mem),
        .bp_lvl(bp_lvl), .seg_lvl(seg_lvl)
    );

    always #2.5 clk = ~clk;

    int    total = 0;
    int    bad = 0;
    int    cyc = 0;
    string cur_req = "R1";
    bit    armed = 0;
    bit    done = 0;

    // reference model state
    int            k_cnt = 0;
    int            m_mode = 3;
    int            m_ps = 0;
    logic [7:0]    exp_bp = '0;
    logic [NS*2-1:0] exp_seg = '0;

    function automatic int sixths_to_code(int v);
        case (v)
            0:       return 0;
            2, 3:    return 1;
            4:       return 2;
            default: return 3;
        endcase
    endfunction

    function automatic int row_of_bp(int mode, int b);
        if (mode == 0) return 0;
        if (mode == 1) return b % 2;
        if (mode == 2) return (b == 3) ? 1 : b;
        return b;
    endfunction

    always @(posedge clk) begin
        int n, f, l, s, ph, rw, fr, dark, swp, blk, mid, bsel, v;
        if (rst) begin
            k_cnt = 0; m_mode = 3; m_ps = 0;
            exp_bp = '0; exp_seg = '0;
        end else begin
            n  = m_mode + 1;
            f  = (m_ps != 0) ? FD / 6 : FD;
            l  = f / (2 * n);
            s  = (k_cnt / l) % (2 * n);
            ph = s / n;
            rw = s % n;
            fr = k_cnt / f;
            dark = (blink_rate != 0) && (((fr >> (3 + int'(blink_rate))) & 1) == 1);
            swp  = dark && blink_swap && (m_mode <= 1);
            blk  = dark && !swp;
            mid  = bias_half || (m_mode == 0);
            bsel = rw + ((((out_bank ? 1 : 0) ^ swp) != 0 && m_mode <= 1) ? 2 : 0);
            for (int b = 0; b < 4; b++) begin
                if (row_of_bp(m_mode, b) == rw) v = ph ? 6 : 0;
                else if (mid) v = 3;
                else v = ph ? 2 : 4;
                exp_bp[b*2 +: 2] = disp_en ? 2'(sixths_to_code(v)) : 2'd0;
            end
            for (int c = 0; c < NS; c++) begin
                if (disp_mem[c*4 + bsel] && !blk) v = ph ? 0 : 6;
                else if (mid) v = ph ? 6 : 0;
                else v = ph ? 4 : 2;
                exp_seg[c*2 +: 2] = disp_en ? 2'(sixths_to_code(v)) : 2'd0;
            end
            if (int'(drive_mode) != m_mode || int'(power_save) != m_ps) begin
                m_mode = int'(drive_mode);
                m_ps   = int'(power_save);
                k_cnt  = 0;
            end else begin
                k_cnt++;
            end
        end
        armed = 1;
    end

    always @(negedge clk) begin
        if (armed && !done) begin
            total++;
            if (bp_lvl !== exp_bp || seg_lvl !== exp_seg) begin
                bad++;
                if (bad < 30)
                    $display("FAIL %s: bp=%h exp %h seg=%h exp %h", cur_req,
                             bp_lvl, exp_bp, seg_lvl, exp_seg);
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, act, expv);
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000 && !done) begin
            done = 1;
            bad++;
            total++;
            $display("FAIL watchdog: cycles=%0d expected below %0d", cyc, 200000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        run(4);
        chk(bp_lvl == '0 && seg_lvl == '0, "R1 reset outputs", {8'h0, bp_lvl, seg_lvl}, 64'h0);
        rst = 1'b0;
        run(10);
        cur_req = "R10";
        chk(bp_lvl == '0 && seg_lvl == '0, "R10 disabled outputs", {8'h0, bp_lvl, seg_lvl}, 64'h0);

        // R4: four rows, third bias
        cur_req = "R4";
        disp_en = 1'b1;
        run(300);
        disp_mem = 96'hFFFF_0000_AAAA_5555_0F0F_F0F0;
        run(300);

        // R2: frame length in power-saving mode, then back
        cur_req = "R2";
        power_save = 1'b1;
        run(60);
        power_save = 1'b0;
        run(300);

        // R3 / R6: row order and backplane sharing
        cur_req = "R3";
        drive_mode = 2'd2;
        run(300);
        cur_req = "R6";
        chk(bp_lvl[7:6] == bp_lvl[3:2], "R6 three-row pair", {56'h0, bp_lvl}, {56'h0, bp_lvl[3:2], bp_lvl[5:4], bp_lvl[3:2], bp_lvl[1:0]});
        drive_mode = 2'd1;
        run(300);
        chk(bp_lvl[5:4] == bp_lvl[1:0] && bp_lvl[7:6] == bp_lvl[3:2], "R6 two-row pairs",
            {56'h0, bp_lvl}, {56'h0, bp_lvl[3:0], bp_lvl[3:0]});
        cur_req = "R3";
        drive_mode = 2'd0;
        run(300);

        // R5: half bias
        cur_req = "R5";
        bias_half = 1'b1;
        drive_mode = 2'd1;
        run(300);
        drive_mode = 2'd2;
        run(300);
        drive_mode = 2'd0;
        run(300);
        bias_half = 1'b0;

        // R7: output bank
        cur_req = "R7";
        out_bank = 1'b1;
        disp_mem = 96'h1248_8421_C3C3_3C3C_6969_9696;
        run(300);
        drive_mode = 2'd1;
        run(300);
        drive_mode = 2'd3;
        run(300);
        out_bank = 1'b0;

        // R8: blink rates
        cur_req = "R8";
        blink_rate = 2'd1;
        run(FD * 40);
        power_save = 1'b1;
        blink_rate = 2'd2;
        run((FD / 6) * 70);
        blink_rate = 2'd3;
        run((FD / 6) * 140);

        // R9: bank-swap blinking
        cur_req = "R9";
        blink_rate = 2'd1;
        blink_swap = 1'b1;
        drive_mode = 2'd1;
        run((FD / 6) * 40);
        drive_mode = 2'd0;
        run((FD / 6) * 40);
        out_bank = 1'b1;
        run((FD / 6) * 40);
        out_bank = 1'b0;
        drive_mode = 2'd3;
        run((FD / 6) * 40);
        blink_swap = 1'b0;
        blink_rate = 2'd0;

        // R10: enable toggling
        cur_req = "R10";
        disp_en = 1'b0;
        run(50);
        chk(bp_lvl == '0 && seg_lvl == '0, "R10 blanked", {8'h0, bp_lvl, seg_lvl}, 64'h0);
        disp_en = 1'b1;
        run(50);

        // R11: restart on configuration change mid-frame
        cur_req = "R11";
        power_save = 1'b0;
        run(53);
        drive_mode = 2'd1;
        run(37);
        power_save = 1'b1;
        run(13);
        drive_mode = 2'd2;
        bias_half = 1'b1;
        run(7);
        drive_mode = 2'd3;
        run(100);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule